// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer for a paged memory system. Each of its entries holds a virtual page number, the physical frame it maps to, and the identifier of the address space (process) that loaded it. A lookup compares the page number of the incoming virtual address against every entry. An entry counts only if its owner identifier equals the current process identifier, or if the entry is marked as shared by all processes. The page offset passes through unchanged.

Every request produces a registered response one cycle later. A successful response carries the physical address. A failed one carries a single exception class, so a software handler can take the right action:

- a privilege violation on the upper half of the address space;
- a miss in the user half;
- a miss in the upper (kernel) half;
- a write to a page that is not yet marked writable.

Software fills entries through a write port at an index it chooses. There is no page-table walker and no replacement policy.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so the first lookup to any address misses, and `rsp_valid` is 0 while reset is held.
- R2: A read lookup whose VPN (address bits 31:12) matches a valid entry with the same 8-bit identifier as `cur_asid` returns `rsp_hit`=1, `rsp_exc`=0 and `rsp_paddr` = {entry frame, address bits 11:0} one cycle after the request.
- R3: An entry whose identifier differs from `cur_asid` and whose global flag is clear does not match. Entries with the same VPN and different identifiers coexist, and each identifier gets its own frame.
- R4: An entry with the global flag set matches whatever the value of `cur_asid`.
- R5: A request with address bit 31 set and `req_user`=1 returns `rsp_exc`=1 (address error) with `rsp_hit`=0, even when an entry would match.
- R6: With no matching entry and address bit 31 clear, `rsp_exc`=2 (user-half miss).
- R7: With no matching entry and address bit 31 set in kernel mode, `rsp_exc`=3 (kernel-half miss).
- R8: A write (`req_write`=1) that matches an entry whose dirty flag is clear returns `rsp_exc`=4 (modify) with `rsp_hit`=0. A read of the same entry hits. Once software rewrites the entry with the dirty flag set, the same write hits.
- R9: When several entries match, the lowest-indexed one supplies the frame and the dirty flag, and `rsp_multi`=1. Otherwise `rsp_multi`=0.
- R10: The write port updates the entry at `wr_idx` on the clock edge. A lookup in the same cycle sees the contents from before the write, and writing `wr_valid`=0 removes the entry.
- R11: `rsp_valid` equals `req_valid` delayed by one cycle. In a cycle with no response, `rsp_hit`, `rsp_exc`, `rsp_paddr` and `rsp_multi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| cur_asid | input | 8 | Identifier of the running process |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Owner identifier to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_dirty | input | 1 | Writable (dirty) flag to store |
| wr_global | input | 1 | Shared-by-all flag to store |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_exc | output | 3 | 0 none, 1 address error, 2 user miss, 3 kernel miss, 4 modify |
| rsp_multi | output | 1 | More than one entry matched |

## Verification
The hardest case to reach from the ports is a double match. Refill by software index normally keeps page numbers unique, so the bench deliberately loads the same page twice: once under a private identifier at a high index, and once as a global entry at a lower index. It then checks that the lower entry wins and that the flag rises. A second delicate case is a lookup that coincides with a write to the very entry it would hit. That stimulus is issued in one cycle so the old contents must be returned. A long stream of random refills and lookups over a handful of page numbers and identifiers is then compared against a behavioural model on every clock.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic              wr_global,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_exc,
  output logic              rsp_multi
);
  localparam logic [2:0] EXC_NONE  = 3'd0;
  localparam logic [2:0] EXC_ADDR  = 3'd1;
  localparam logic [2:0] EXC_UMISS = 3'd2;
  localparam logic [2:0] EXC_KMISS = 3'd3;
  localparam logic [2:0] EXC_MOD   = 3'd4;

  logic [ENTRIES-1:0] t_v, t_d, t_g;
  logic [VPN_W-1:0]   t_vpn  [ENTRIES];
  logic [ASID_W-1:0]  t_asid [ENTRIES];
  logic [PFN_W-1:0]   t_pfn  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) t_v <= '0;
    else if (wr_en) t_v[wr_idx] <= wr_valid;

  always_ff @(posedge clk)
    if (wr_en) begin
      t_d[wr_idx]    <= wr_dirty;
      t_g[wr_idx]    <= wr_global;
      t_vpn[wr_idx]  <= wr_vpn;
      t_asid[wr_idx] <= wr_asid;
      t_pfn[wr_idx]  <= wr_pfn;
    end

  wire [VPN_W-1:0] va_vpn   = req_vaddr[VA_W-1:PAGE_BITS];
  wire             seg_hi   = req_vaddr[VA_W-1];
  wire             addr_err = seg_hi & req_user;

  logic [ENTRIES-1:0] match;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = t_v[i] && (t_vpn[i] == va_vpn) &&
                      (t_g[i] || (t_asid[i] == cur_asid));
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  wire any   = |match;
  wire multi = !addr_err && ((match & (match - 1'b1)) != '0);

  logic [2:0] exc;
  always_comb begin
    if (addr_err)                    exc = EXC_ADDR;
    else if (!any)                   exc = seg_hi ? EXC_KMISS : EXC_UMISS;
    else if (req_write && !t_d[sel]) exc = EXC_MOD;
    else                             exc = EXC_NONE;
  end

  wire hit = (exc == EXC_NONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_exc   <= EXC_NONE;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & hit;
      rsp_paddr <= (req_valid && hit) ? {t_pfn[sel], req_vaddr[PAGE_BITS-1:0]} : '0;
      rsp_exc   <= req_valid ? exc : EXC_NONE;
      rsp_multi <= req_valid & multi;
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_write,
  input logic            req_user,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_exc,
  input logic            rsp_multi
);
  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && rsp_exc == 3'd0 && !rsp_multi));
  // R5
  addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && req_vaddr[VA_W-1]) |=> (rsp_exc == 3'd1 && !rsp_hit && !rsp_multi));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));
  // R8
  read_no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_exc != 3'd4);
  // R6
  low_half_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_vaddr[VA_W-1]) |=> (rsp_exc != 3'd1 && rsp_exc != 3'd3));
  // R7
  high_half_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[VA_W-1]) |=> rsp_exc != 3'd2);
  // R2
  hit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_exc == 3'd0));
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc), .rsp_multi(rsp_multi)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_vaddr = 0;
  logic [7:0]  cur_asid = 0;
  logic        wr_en = 0, wr_valid = 0, wr_dirty = 0, wr_global = 0;
  logic [3:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0, wr_pfn = 0;
  logic [7:0]  wr_asid = 0;
  logic        rsp_valid, rsp_hit, rsp_multi;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_exc;

  asid_tlb u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  int m_v[16], m_d[16], m_g[16], m_vpn[16], m_asid[16], m_pfn[16];

  int e_valid, e_hit, e_exc, e_multi;
  longint e_paddr;

  function automatic void model_lookup();
    int first, count;
    first = -1; count = 0;
    e_valid = req_valid; e_hit = 0; e_exc = 0; e_multi = 0; e_paddr = 0;
    if (!req_valid) return;
    if (req_vaddr[31] && req_user) begin e_exc = 1; return; end
    foreach (m_v[i])
      if (m_v[i] != 0 && m_vpn[i] == int'(req_vaddr[31:12]) &&
          (m_g[i] != 0 || m_asid[i] == int'(cur_asid))) begin
        if (first < 0) first = i;
        count++;
      end
    e_multi = (count > 1);
    if (first < 0) e_exc = req_vaddr[31] ? 3 : 2;
    else if (req_write && m_d[first] == 0) e_exc = 4;
    else begin
      e_hit = 1;
      e_paddr = longint'(m_pfn[first]) * 4096 + req_vaddr[11:0];
    end
  endfunction

  function automatic void model_write();
    if (!wr_en) return;
    m_v[wr_idx] = wr_valid; m_d[wr_idx] = wr_dirty; m_g[wr_idx] = wr_global;
    m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid; m_pfn[wr_idx] = wr_pfn;
  endfunction

  task automatic step(input string tag);
    model_lookup();
    @(posedge clk);
    model_write();
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'(e_valid) || rsp_hit !== 1'(e_hit) || rsp_exc !== 3'(e_exc) ||
        rsp_multi !== 1'(e_multi) || rsp_paddr !== 32'(e_paddr)) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b exc=%0d multi=%0b pa=%h, expected v=%0d h=%0d exc=%0d multi=%0d pa=%h",
               tag, rsp_valid, rsp_hit, rsp_exc, rsp_multi, rsp_paddr,
               e_valid, e_hit, e_exc, e_multi, 32'(e_paddr));
    end
    req_valid = 0; wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr, input logic [7:0] asid);
    req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr; cur_asid = asid;
  endtask

  task automatic fill(input int idx, input int vpn, input int asid, input int pfn,
                      input logic v, input logic d, input logic g);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = 20'(vpn); wr_asid = 8'(asid); wr_pfn = 20'(pfn);
    wr_valid = v; wr_dirty = d; wr_global = g;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_v[i]) m_v[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1: got rsp_valid=%0b, expected 0", rsp_valid);
    end
    rst_n = 1;
    @(negedge clk);
    look(32'h0000_1234, 0, 0, 8'd5); step("R1 R6 empty miss");
    look(32'h8000_1234, 0, 0, 8'd5); step("R7 empty kernel miss");

    fill(3, 'h00012, 5, 'hABCDE, 1, 0, 0);
    look(32'h0001_2345, 0, 1, 8'd5); step("R10 same-cycle old contents");
    look(32'h0001_2345, 0, 1, 8'd5); step("R2 hit");
    look(32'h0001_2FFF, 0, 0, 8'd5); step("R2 offset");
    look(32'h0001_2345, 0, 1, 8'd6); step("R3 asid mismatch");
    fill(4, 'h00012, 6, 'h11111, 1, 1, 0); step("R10 idle write");
    look(32'h0001_2345, 0, 1, 8'd6); step("R3 second owner");
    look(32'h0001_2345, 0, 1, 8'd5); step("R3 first owner kept");
    look(32'h0001_2345, 1, 1, 8'd5); step("R8 modify");
    look(32'h0001_2345, 1, 1, 8'd6); step("R8 dirty write hits");
    fill(3, 'h00012, 5, 'hABCDE, 1, 1, 0); step("R8 set dirty");
    look(32'h0001_2345, 1, 1, 8'd5); step("R8 retry hits");

    fill(7, 'h80005, 9, 'h22222, 1, 1, 1); step("R4 fill global");
    look(32'h8000_5010, 0, 0, 8'd0);   step("R4 global asid 0");
    look(32'h8000_5010, 1, 0, 8'd200); step("R4 global asid 200");
    look(32'h8000_5010, 0, 1, 8'd9);   step("R5 user high half");
    look(32'h8000_6010, 0, 0, 8'd9);   step("R7 kernel miss");
    look(32'h7FFF_F000, 0, 1, 8'd9);   step("R6 user miss");

    fill(9, 'h00030, 5, 'h33333, 1, 1, 0); step("R9 fill high");
    fill(2, 'h00030, 77, 'h44444, 1, 0, 1); step("R9 fill low global");
    look(32'h0003_0ABC, 0, 0, 8'd5); step("R9 lowest wins");
    look(32'h0003_0ABC, 1, 0, 8'd5); step("R9 lowest dirty decides");
    look(32'h0003_0ABC, 0, 0, 8'd8); step("R9 single match");

    fill(3, 'h00012, 5, 'hABCDE, 0, 1, 0); step("R10 invalidate");
    look(32'h0001_2345, 0, 0, 8'd5); step("R10 invalidated miss");
    step("R11 idle");
    step("R11 idle");

    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3) == 0)
        fill($urandom_range(15), ($urandom_range(1) ? 'h80000 : 0) + $urandom_range(3),
             $urandom_range(2), $urandom(), 1'($urandom_range(4) != 0),
             1'($urandom_range(1)), 1'($urandom_range(5) == 0));
      if ($urandom_range(4) != 0)
        look({$urandom_range(1) ? 20'h80000 : 20'h0 | 20'($urandom_range(3)), 12'($urandom())} |
             {20'($urandom_range(3)), 12'h0},
             1'($urandom_range(1)), 1'($urandom_range(1)), 8'($urandom_range(2)));
      step("R2 R11 random stream");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule